// File: doc/BRIEF.md
# UART Masked Interrupt Cause Unit

This unit sits between the FIFOs and line logic of a UART and the interrupt controller. It watches ten event sources and latches each one into its own cause bit: receive data over threshold, transmit space over threshold, a receive idle timeout, line errors, modem status changes, three DMA completion events, and rising and falling edges of the DTR input. A mask register gates the latched causes onto one interrupt line. Software reads two values. The mask word holds the enables. The cause word holds the masked latched causes in its low half and the unmasked live source status in its upper half.

Software has one write port with a two-bit register select. A mask write replaces the enables. A cause write clears each latched bit that is set in the written word. A trigger write sets the receive and transmit threshold levels. The receive idle timeout is counted in bit-clock ticks that the serial logic supplies. The FIFOs, the shifters and the baud generator are outside this unit. No data moves through it, so every pin is a plain control or status signal and none uses a valid/ready handshake.

Top module: `uart_irq_cause`

## Requirements
- R1: After reset, `mask_rd` and `cause_rd` read 0 and `irq` is low while every source input is inactive.
- R2: A write with `reg_sel`=0 stores `reg_wdata[9:0]` as the mask. `mask_rd` returns the stored bits in [9:0] and zeros in every other bit.
- R3: Cause bit positions are fixed: 0 modem change, 1 RX data available, 2 TX data needed, 3 RX idle timeout, 4 line error, 5 TX DMA done, 6 RX DMA done, 7 RX DMA timeout, 8 DTR rise, 9 DTR fall. `cause_rd[9:0]` is the latched cause ANDed with the mask. `cause_rd[25:16]` is the live, unmasked status of the same sources. All other bits read 0.
- R4: An active source sets its latched bit at the next clock edge. The bit stays set after the source goes away.
- R5: A write with `reg_sel`=1 clears each latched bit whose `reg_wdata` bit is 1 and leaves the others alone. If a source is active in the same cycle, its bit stays set, so a level source that is still active cannot be cleared.
- R6: A write with `reg_sel`=2 loads the receive trigger from `reg_wdata[4:0]` and the transmit trigger from `reg_wdata[11:8]`. Source 1 is active while `rx_level` >= the receive trigger. Source 2 is active while `tx_free` >= the transmit trigger.
- R7: While `rx_level` is nonzero and neither `rx_pop` nor `rx_busy` is high, the unit counts `bit_tick` pulses. The 40th tick (4 characters of 10 bits) raises source 3 for exactly one cycle. The count then holds and gives no further pulse until it restarts. The count restarts at 0 whenever the FIFO is empty, a character is popped, or the receiver is busy.
- R8: `dtr_in` passes through a two-flop synchroniser. A 0-to-1 change raises source 8 and a 1-to-0 change raises source 9, each for one cycle. Each is latched within four clock edges of the input change.
- R9: `irq` is the OR of the latched causes ANDed with their mask bits. After a mask write of zero, `irq` is low from the next cycle on. The latched causes are kept, and re-enabling the mask shows them again.
- R10: Both triggers reset to 1, so right after reset source 1 follows `rx_level` >= 1 and source 2 follows `tx_free` >= 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mask, 1 cause clear, 2 triggers |
| reg_wdata | input | 32 | Register write data |
| rx_level | input | 7 | Receive FIFO fill level |
| tx_free | input | 5 | Transmit FIFO free entries |
| rx_pop | input | 1 | A character was read from the receive FIFO |
| rx_busy | input | 1 | Receiver is shifting in a character |
| bit_tick | input | 1 | One pulse per serial bit time |
| modem_chg | input | 1 | Modem status change event |
| line_err | input | 1 | Receive line error (parity, framing, overrun, break) |
| tx_dma_done | input | 1 | Transmit DMA complete event |
| rx_dma_done | input | 1 | Receive DMA complete event |
| rx_dma_tmo | input | 1 | Receive DMA timeout event |
| dtr_in | input | 1 | Asynchronous DTR line |
| mask_rd | output | 32 | Mask register read value |
| cause_rd | output | 32 | Cause register read value |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check the latch behaviour on every cycle. An active source always leaves its bit set. A clear with no competing source always removes the bit. An idle-timeout pulse never lasts longer than one cycle, and a zero mask write always silences the interrupt. Only the bench scenarios can show the threshold arithmetic, the exact tick count at which the idle timeout fires, and how far the count is reset. The same holds for the synchroniser latency of the DTR edges and the bit layout of the read words. The bench sweeps every trigger value against a span of levels and compares against comparisons it computes itself.

// File: rtl/uart_icu_pkg.sv
package uart_icu_pkg;
  localparam int NUM_SRC   = 10;
  localparam int RAW_SHIFT = 16;

  localparam int SRC_MODEM    = 0;
  localparam int SRC_RX_AVAIL = 1;
  localparam int SRC_TX_NEED  = 2;
  localparam int SRC_RX_IDLE  = 3;
  localparam int SRC_LINE_ERR = 4;
  localparam int SRC_TX_DMA   = 5;
  localparam int SRC_RX_DMA   = 6;
  localparam int SRC_RX_DMATO = 7;
  localparam int SRC_DTR_RISE = 8;
  localparam int SRC_DTR_FALL = 9;

  localparam int RX_TRIG_LSB = 0;
  localparam int TX_TRIG_LSB = 8;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_TRIG  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/uart_icu_dtr_edge.sv
module uart_icu_dtr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic dtr_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= dtr_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/uart_icu_idle_timer.sv
module uart_icu_idle_timer #(
  parameter int CHAR_BITS  = 10,
  parameter int IDLE_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nonempty_i,
  input  logic pop_i,
  input  logic busy_i,
  input  logic tick_i,
  output logic fire_o
);
  localparam int LIMIT = CHAR_BITS * IDLE_CHARS;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V  = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          restart;

  assign restart = ~nonempty_i | pop_i | busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != LIMIT_V) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = tick_i & ~restart & (cnt_q == LAST_V);

  // R7
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

  // R7
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == LIMIT_V) || restart);
endmodule

// File: rtl/uart_icu_cause_bits.sv
module uart_icu_cause_bits #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lat_q <= 1'b0;
      else if (set_i[i]) lat_q <= 1'b1;
      else if (clr_i[i]) lat_q <= 1'b0;
    end

    assign lat_o[i] = lat_q;

    // R4
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> lat_o[i]);

    // R5
    latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !lat_o[i]);
  end
endmodule

// File: rtl/uart_irq_cause.sv
module uart_irq_cause
  import uart_icu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RX_LVL_W   = 7,
  parameter int TX_FREE_W  = 5,
  parameter int RX_TRIG_W  = 5,
  parameter int TX_TRIG_W  = 4,
  parameter int CHAR_BITS  = 10,
  parameter int IDLE_CHARS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_sel,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic [RX_LVL_W-1:0]  rx_level,
  input  logic [TX_FREE_W-1:0] tx_free,
  input  logic                 rx_pop,
  input  logic                 rx_busy,
  input  logic                 bit_tick,
  input  logic                 modem_chg,
  input  logic                 line_err,
  input  logic                 tx_dma_done,
  input  logic                 rx_dma_done,
  input  logic                 rx_dma_tmo,
  input  logic                 dtr_in,
  output logic [DATA_W-1:0]    mask_rd,
  output logic [DATA_W-1:0]    cause_rd,
  output logic                 irq
);
  localparam int RX_PAD = RX_LVL_W - RX_TRIG_W;
  localparam int TX_PAD = TX_FREE_W - TX_TRIG_W;

  logic [NUM_SRC-1:0]   mask_q;
  logic [RX_TRIG_W-1:0] rx_trig_q;
  logic [TX_TRIG_W-1:0] tx_trig_q;
  logic [NUM_SRC-1:0]   raw;
  logic [NUM_SRC-1:0]   clr;
  logic [NUM_SRC-1:0]   lat;
  logic                 idle_fire, dtr_rise, dtr_fall;
  logic                 wr_mask, wr_cause, wr_trig;
  logic                 unused_wdata;

  assign wr_mask  = reg_we && (reg_sel == SEL_MASK);
  assign wr_cause = reg_we && (reg_sel == SEL_CAUSE);
  assign wr_trig  = reg_we && (reg_sel == SEL_TRIG);
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      rx_trig_q <= RX_TRIG_W'(1);
      tx_trig_q <= TX_TRIG_W'(1);
    end else begin
      if (wr_mask) mask_q <= reg_wdata[NUM_SRC-1:0];
      if (wr_trig) begin
        rx_trig_q <= reg_wdata[RX_TRIG_LSB +: RX_TRIG_W];
        tx_trig_q <= reg_wdata[TX_TRIG_LSB +: TX_TRIG_W];
      end
    end
  end

  uart_icu_idle_timer #(
    .CHAR_BITS (CHAR_BITS),
    .IDLE_CHARS(IDLE_CHARS)
  ) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .nonempty_i(rx_level != '0),
    .pop_i     (rx_pop),
    .busy_i    (rx_busy),
    .tick_i    (bit_tick),
    .fire_o    (idle_fire)
  );

  uart_icu_dtr_edge u_dtr (
    .clk   (clk),
    .rst_n (rst_n),
    .dtr_i (dtr_in),
    .rise_o(dtr_rise),
    .fall_o(dtr_fall)
  );

  always_comb begin
    raw               = '0;
    raw[SRC_MODEM]    = modem_chg;
    raw[SRC_RX_AVAIL] = rx_level >= {{RX_PAD{1'b0}}, rx_trig_q};
    raw[SRC_TX_NEED]  = tx_free >= {{TX_PAD{1'b0}}, tx_trig_q};
    raw[SRC_RX_IDLE]  = idle_fire;
    raw[SRC_LINE_ERR] = line_err;
    raw[SRC_TX_DMA]   = tx_dma_done;
    raw[SRC_RX_DMA]   = rx_dma_done;
    raw[SRC_RX_DMATO] = rx_dma_tmo;
    raw[SRC_DTR_RISE] = dtr_rise;
    raw[SRC_DTR_FALL] = dtr_fall;
  end

  assign clr = wr_cause ? reg_wdata[NUM_SRC-1:0] : '0;

  uart_icu_cause_bits #(.N(NUM_SRC)) u_cause (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(raw),
    .clr_i(clr),
    .lat_o(lat)
  );

  always_comb begin
    mask_rd                       = '0;
    mask_rd[NUM_SRC-1:0]          = mask_q;
    cause_rd                      = '0;
    cause_rd[NUM_SRC-1:0]         = lat & mask_q;
    cause_rd[RAW_SHIFT +: NUM_SRC] = raw;
  end

  assign irq = |(lat & mask_q);

  // R9
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && reg_wdata[NUM_SRC-1:0] == '0) |=> !irq);

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask_rd[NUM_SRC-1:0] == $past(reg_wdata[NUM_SRC-1:0]));
endmodule

// File: tb/uart_irq_cause_tb.sv
module uart_irq_cause_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [6:0]  rx_level = '0;
  logic [4:0]  tx_free = '0;
  logic        rx_pop = 0, rx_busy = 0, bit_tick = 0;
  logic        modem_chg = 0, line_err = 0, tx_dma_done = 0;
  logic        rx_dma_done = 0, rx_dma_tmo = 0, dtr_in = 0;
  logic [31:0] mask_rd, cause_rd;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_cause u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rx_level(rx_level), .tx_free(tx_free),
    .rx_pop(rx_pop), .rx_busy(rx_busy), .bit_tick(bit_tick),
    .modem_chg(modem_chg), .line_err(line_err), .tx_dma_done(tx_dma_done),
    .rx_dma_done(rx_dma_done), .rx_dma_tmo(rx_dma_tmo), .dtr_in(dtr_in),
    .mask_rd(mask_rd), .cause_rd(cause_rd), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    step(1);
    reg_we = 1'b0; reg_wdata = '0;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      bit_tick = 1'b1; step(1);
      bit_tick = 1'b0; step(1);
    end
  endtask

  task automatic pulse_src(input int idx);
    case (idx)
      0: modem_chg = 1'b1;
      4: line_err = 1'b1;
      5: tx_dma_done = 1'b1;
      6: rx_dma_done = 1'b1;
      default: rx_dma_tmo = 1'b1;
    endcase
    step(1);
    {modem_chg, line_err, tx_dma_done, rx_dma_done, rx_dma_tmo} = '0;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    chk("R1 mask", mask_rd, 32'h0);
    chk("R1 cause", cause_rd, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    // R10 default triggers of 1
    rx_level = 7'd1; tx_free = 5'd1; #1;
    chk("R10 defaults", cause_rd & 32'h0006_0000, 32'h0006_0000);
    rx_level = 0; tx_free = 0; #1;
    step(1);
    wr(2'd1, 32'h3FF);

    // R2
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R2 mask upper zero", mask_rd, 32'h0000_03FF);
    wr(2'd0, 32'h0000_0155);
    chk("R2 mask value", mask_rd, 32'h0000_0155);

    // R6 receive threshold sweep
    wr(2'd0, 32'h0);
    for (int t = 0; t < 32; t++) begin
      wr(2'd2, 32'h100 | t);
      for (int lv = 0; lv <= 40; lv++) begin
        rx_level = 7'(lv); #1;
        chk("R6 rx trigger", {31'b0, cause_rd[17]}, {31'b0, lv >= t});
      end
    end
    rx_level = 0;
    // R6 transmit threshold sweep
    for (int t = 0; t < 16; t++) begin
      wr(2'd2, (t << 8) | 32'h1F);
      for (int fr = 0; fr < 32; fr++) begin
        tx_free = 5'(fr); #1;
        chk("R6 tx trigger", {31'b0, cause_rd[18]}, {31'b0, fr >= t});
      end
    end
    tx_free = 0;
    wr(2'd2, 32'h0000_0101);
    step(1);
    wr(2'd1, 32'h3FF);

    // R3 R4 pulse sources land at fixed positions and stick
    wr(2'd0, 32'h3FF);
    for (int i = 0; i < 8; i++) begin
      if (i >= 1 && i <= 3) continue;
      pulse_src(i);
      chk("R4 latched bit", cause_rd, 32'(1) << i);
      chk("R3 raw gone", cause_rd[25:16], 10'h0);
      chk("R9 irq on", {31'b0, irq}, 32'h1);
      wr(2'd1, 32'(1) << i);
      chk("R5 cleared", cause_rd, 32'h0);
    end
    // R3 raw bit at +16 while source active
    line_err = 1'b1; #1;
    chk("R3 raw line err", cause_rd & 32'h0010_0000, 32'h0010_0000);
    // R5 clear collides with active source
    reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h10;
    step(1);
    reg_we = 1'b0; line_err = 1'b0; #1;
    chk("R5 set wins", cause_rd, 32'h10);
    // R9 mask off keeps latch
    wr(2'd0, 32'h0);
    chk("R9 irq off", {31'b0, irq}, 32'h0);
    chk("R9 masked read", cause_rd, 32'h0);
    wr(2'd0, 32'h10);
    chk("R9 latch kept", cause_rd, 32'h10);
    wr(2'd1, 32'h10);
    chk("R5 clear line err", cause_rd, 32'h0);
    // R5 level source re-latches
    wr(2'd0, 32'h2);
    rx_level = 7'd5; step(1);
    wr(2'd1, 32'h2);
    chk("R5 level persists", cause_rd[9:0], 10'h2);
    rx_level = 0; step(1);
    wr(2'd1, 32'h2);
    chk("R5 level cleared", cause_rd[9:0], 10'h0);

    // R7 idle timeout
    wr(2'd2, 32'h0000_011F);
    wr(2'd0, 32'h8);
    rx_level = 7'd3; step(1);
    ticks(39);
    chk("R7 before limit", cause_rd[9:0], 10'h0);
    rx_pop = 1'b1; step(1); rx_pop = 1'b0; #1;
    ticks(39);
    chk("R7 pop restarts", cause_rd[9:0], 10'h0);
    ticks(1);
    chk("R7 fires at 40", cause_rd[9:0], 10'h8);
    chk("R7 irq", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h8);
    ticks(45);
    chk("R7 single pulse", cause_rd[9:0], 10'h0);
    rx_busy = 1'b1; step(1); rx_busy = 1'b0; #1;
    ticks(30);
    rx_busy = 1'b1; step(1); rx_busy = 1'b0; #1;
    ticks(39);
    chk("R7 busy restarts", cause_rd[9:0], 10'h0);
    ticks(1);
    chk("R7 refire", cause_rd[9:0], 10'h8);
    wr(2'd1, 32'h8);
    rx_level = 0; step(1);
    ticks(50);
    chk("R7 empty no fire", cause_rd[9:0], 10'h0);

    // R8 DTR edges
    wr(2'd0, 32'h300);
    dtr_in = 1'b1;
    step(4);
    chk("R8 rise", cause_rd[9:0], 10'h100);
    wr(2'd1, 32'h100);
    dtr_in = 1'b0;
    step(4);
    chk("R8 fall", cause_rd[9:0], 10'h200);
    wr(2'd1, 32'h200);
    step(4);
    chk("R8 quiet", cause_rd[9:0], 10'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule